// File: doc/BRIEF.md
# Card Bus Clock Divider

This block derives the clock for a memory-card bus from the host clock by dividing it by a power of two between 2 and 512. Software sets the rate and turns the bus clock on or off through a clock-control register. A second register, the bus-option word, chooses between a one-line and a four-line data bus and drives a width-select output. The card protocol engine that uses the width select sits outside this block.

The programmed selector and enable do not reach the toggle logic at once. They are taken into an active copy only while the card clock is low. A high phase that has already begun therefore always runs its full length, and a rate change never produces a runt pulse on the card bus. Software picks the fastest setting that does not exceed the target card frequency. The block rounds down by construction, because every setting is an exact power-of-two division.

The register port is a plain single-cycle write strobe with a combinational read of the addressed register. There is no data stream, so no valid/ready handshake is used and no back-pressure exists. A write is never refused.

Top module: `card_clk_div`

## Requirements
- R1: After reset, card_clk is low, wide_bus is 0, address 0 reads 0x0000 and address 1 reads 0x80E0.
- R2: While bit 8 of the clock-control register (address 0) is clear, card_clk stays low. A high phase already running when the bit is cleared still ends normally.
- R3: With bit 8 set and exactly one of selector bits 7:0 set at position i, card_clk has a period of 2^(i+2) host cycles, with high and low phases of 2^(i+1) cycles each. Bit 7 gives divide by 512.
- R4: With bit 8 set and selector bits 7:0 all zero, card_clk toggles on every host cycle, which is divide by 2.
- R5: When several selector bits are set, the highest set bit alone sets the rate.
- R6: A new selector or enable value is applied only while card_clk is low. A high phase in progress keeps the length given by the setting in force when it began.
- R7: wide_bus is 1 (four-line mode) when bit 15 of the bus-option register (address 1) is clear, and 0 (one-line mode) when it is set. The other bits of that register do not affect wide_bus or card_clk.
- R8: Reads return the last value written. Address 0 keeps bits 8:0 and reads bits 15:9 as zero. Address 1 keeps all 16 bits. A write to address 2 or 3 changes nothing, and those addresses read zero.
- R9: Starting from the stopped state, the first low phase of card_clk lasts half the selected period. It is counted from the host clock edge that captures the enabling write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| card_clk | output | 1 | Divided card bus clock |
| wide_bus | output | 1 | 1 selects four-line data, 0 selects one-line data |

## Verification
The bench sweeps all nine single-setting selectors, from all-zero up to bit 7. For each one it measures both phase lengths of a settled card clock, so an off-by-one in the count or a duty error shows up for that exact setting. Selectors with several bits set, including all ones, separate highest-bit priority from lowest-bit or OR-style decoding. A switch from divide-by-512 to divide-by-2 made in the middle of a high phase, together with start-up latency counts from the stopped state, separates low-phase-only updates from immediate ones. Disabling, bus-option values with and without bit 15, and writes to unused addresses show that each control reaches only its own output.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CLKCTL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_BUSOPT = 2'd1;
  localparam logic [DATA_W-1:0] BUSOPT_RESET = 16'h80E0;
  localparam int NARROW_BIT = 15;
endpackage

// File: rtl/ckdiv_regs.sv
module ckdiv_regs
  import ckdiv_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SEL_W-1:0]  prog_sel,
  output logic              prog_en,
  output logic              narrow
);
  localparam int CTL_W = SEL_W + 1;

  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] opt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      opt_q <= BUSOPT_RESET;
    end else if (wr) begin
      if (addr == ADDR_CLKCTL) ctl_q <= wdata[CTL_W-1:0];
      if (addr == ADDR_BUSOPT) opt_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CLKCTL) rdata[CTL_W-1:0] = ctl_q;
    else if (addr == ADDR_BUSOPT) rdata = opt_q;
  end

  assign prog_sel = ctl_q[SEL_W-1:0];
  assign prog_en  = ctl_q[SEL_W];
  assign narrow   = opt_q[NARROW_BIT];
endmodule

// File: rtl/ckdiv_decode.sv
module ckdiv_decode #(
  parameter int SEL_W = 8,
  localparam int CNT_W = SEL_W + 1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] half
);
  // highest set bit wins; empty selector means half period of one cycle
  always_comb begin
    half = CNT_W'(1);
    for (int i = 0; i < SEL_W; i++) begin
      if (sel[i]) half = CNT_W'(1) << (i + 1);
    end
  end
endmodule

// File: rtl/ckdiv_gen.sv
module ckdiv_gen #(
  parameter int SEL_W = 8,
  localparam int CNT_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] prog_sel,
  input  logic             prog_en,
  output logic [SEL_W-1:0] act_sel,
  output logic             act_en,
  output logic             card_clk
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;
  logic [SEL_W-1:0] sel_eff;
  logic             en_eff;
  logic             clk_q;

  // new settings pass through only during the low phase
  assign sel_eff = clk_q ? act_sel : prog_sel;
  assign en_eff  = clk_q ? act_en  : prog_en;

  ckdiv_decode #(.SEL_W(SEL_W)) dec_i (
    .sel  (sel_eff),
    .half (half)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= '0;
      act_en  <= 1'b0;
    end else if (!clk_q) begin
      act_sel <= prog_sel;
      act_en  <= prog_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!en_eff) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (cnt_q >= half - CNT_W'(1)) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign card_clk = clk_q;
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import ckdiv_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              card_clk,
  output logic              wide_bus
);
  logic [SEL_W-1:0] prog_sel;
  logic             prog_en;
  logic             narrow;
  logic [SEL_W-1:0] act_sel;
  logic             act_en;

  ckdiv_regs #(.SEL_W(SEL_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .prog_sel (prog_sel),
    .prog_en  (prog_en),
    .narrow   (narrow)
  );

  ckdiv_gen #(.SEL_W(SEL_W)) gen_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_sel (prog_sel),
    .prog_en  (prog_en),
    .act_sel  (act_sel),
    .act_en   (act_en),
    .card_clk (card_clk)
  );

  assign wide_bus = ~narrow;
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk
  import ckdiv_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              card_clk,
  input logic              wide_bus,
  input logic              prog_en,
  input logic [SEL_W-1:0]  act_sel,
  input logic              act_en
);
  localparam int LEN_W = SEL_W + 2;

  logic [LEN_W-1:0] hi_len;
  logic [LEN_W-1:0] exp_half;

  // expected half period from the active selector, searched top down
  always_comb begin
    exp_half = LEN_W'(1);
    for (int i = SEL_W - 1; i >= 0; i--) begin
      if (act_sel[i] && exp_half == LEN_W'(1)) exp_half = LEN_W'(2) ** (i + 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= '0;
    else if (card_clk) hi_len <= hi_len + LEN_W'(1);
    else hi_len <= '0;
  end

  p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_en && !card_clk) |=> !card_clk);

  p_full_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk) |-> hi_len == exp_half);

  p_frozen_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (card_clk && $past(card_clk)) |-> ($stable(act_sel) && $stable(act_en)));

  p_width_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_BUSOPT) |=> wide_bus == !$past(reg_wdata[NARROW_BIT]));

  p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_BUSOPT) ##1 (reg_addr == ADDR_BUSOPT && !reg_wr)
      |-> reg_rdata == $past(reg_wdata));

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1]) |-> reg_rdata == '0);
endmodule

bind card_clk_div card_clk_div_chk #(.SEL_W(SEL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .card_clk  (card_clk),
  .wide_bus  (wide_bus),
  .prog_en   (prog_en),
  .act_sel   (act_sel),
  .act_en    (act_en)
);

// File: tb/card_clk_div_tb_top.sv
module card_clk_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        card_clk;
  logic        wide_bus;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  card_clk_div dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .card_clk  (card_clk),
    .wide_bus  (wide_bus)
  );

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
      finish_run();
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  // measure one full period: high length then low length
  task automatic measure(output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    @(negedge clk);
    while (card_clk && guard < 3000) begin @(negedge clk); guard++; end
    while (!card_clk && guard < 3000) begin @(negedge clk); guard++; end
    while (card_clk && guard < 3000) begin hi++; @(negedge clk); guard++; end
    while (!card_clk && guard < 3000) begin lo++; @(negedge clk); guard++; end
  endtask

  task automatic low_for(int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (card_clk) highs++;
    end
  endtask

  initial begin
    int v, hi, lo, hc, n, highs;
    logic [7:0] sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 card_clk", int'(card_clk), 0);
    check("R1 wide_bus", int'(wide_bus), 0);
    rd(2'd0, v); check("R1 clkctl", v, 0);
    rd(2'd1, v); check("R1 busopt", v, 'h80E0);
    // R2 clock stays low while disabled after reset
    low_for(100, highs); check("R2 idle highs", highs, 0);

    // R3/R4 sweep of every single-setting selector
    for (int s = 0; s <= 8; s++) begin
      sel = (s == 0) ? 8'h00 : 8'(1 << (s - 1));
      wr(2'd0, {7'd0, 1'b1, sel});
      rd(2'd0, v); check("R8 clkctl readback", v, {1'b1, sel});
      measure(hi, lo);
      measure(hi, lo);
      if (s == 0) begin
        check("R4 div2 high", hi, 1); check("R4 div2 low", lo, 1);
      end else begin
        check($sformatf("R3 sel bit %0d high", s - 1), hi, 1 << s);
        check($sformatf("R3 sel bit %0d low", s - 1), lo, 1 << s);
      end
    end

    // R5 highest bit wins
    wr(2'd0, 16'h0105); measure(hi, lo); measure(hi, lo);
    check("R5 0x05 high", hi, 8); check("R5 0x05 low", lo, 8);
    wr(2'd0, 16'h01FF); measure(hi, lo); measure(hi, lo);
    check("R5 0xFF high", hi, 256); check("R5 0xFF low", lo, 256);

    // R6 switch to div2 in the middle of a 512 high phase
    while (card_clk) @(negedge clk);
    while (!card_clk) @(negedge clk);
    hc = 0;
    while (card_clk && hc < 3000) begin
      hc++;
      if (hc == 4) begin reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0100; end
      if (hc == 5) reg_wr = 1'b0;
      @(negedge clk);
    end
    check("R6 high phase kept", hc, 256);
    n = 0;
    while (!card_clk && n < 3000) begin n++; @(negedge clk); end
    check("R6 first low after switch", n, 1);
    measure(hi, lo);
    check("R6 new rate high", hi, 1); check("R6 new rate low", lo, 1);

    // R2 disable while running at divide by 8
    wr(2'd0, 16'h0102); measure(hi, lo);
    wr(2'd0, 16'h0002);
    repeat (20) @(negedge clk);
    low_for(600, highs); check("R2 disabled highs", highs, 0);

    // R9 start-up latency from stopped state
    wr(2'd0, 16'h0100);
    n = 0;
    while (!card_clk && n < 3000) begin @(negedge clk); n++; end
    check("R9 start div2", n, 1);
    wr(2'd0, 16'h0000); repeat (10) @(negedge clk);
    wr(2'd0, 16'h0104);
    n = 0;
    while (!card_clk && n < 3000) begin @(negedge clk); n++; end
    check("R9 start div16", n, 8);

    // R7 bus width select
    wr(2'd1, 16'h00E0); @(negedge clk); check("R7 0x00E0 wide", int'(wide_bus), 1);
    wr(2'd1, 16'h80E0); @(negedge clk); check("R7 0x80E0 narrow", int'(wide_bus), 0);
    wr(2'd1, 16'h7FFF); @(negedge clk); check("R7 0x7FFF wide", int'(wide_bus), 1);
    measure(hi, lo); measure(hi, lo);
    check("R7 clock unaffected high", hi, 8); check("R7 clock unaffected low", lo, 8);

    // R8 readback, truncation and unused addresses
    wr(2'd0, 16'hFFFF); rd(2'd0, v); check("R8 clkctl upper bits", v, 'h01FF);
    wr(2'd1, 16'hA5C3); rd(2'd1, v); check("R8 busopt", v, 'hA5C3);
    wr(2'd2, 16'h1234); wr(2'd3, 16'h5678);
    rd(2'd0, v); check("R8 clkctl after unused", v, 'h01FF);
    rd(2'd1, v); check("R8 busopt after unused", v, 'hA5C3);
    rd(2'd2, v); check("R8 addr2 zero", v, 0);
    rd(2'd3, v); check("R8 addr3 zero", v, 0);

    finish_run();
  end
endmodule